// File: doc/BRIEF.md
# Coupled Probabilistic Bit Array

This block holds a small network of digital probabilistic bits. Each bit draws a fresh random value and takes state 1 with a probability that rises with its input. The input is a weighted sum over the states of all the other bits plus a bias. Because each bit's input depends on the other bits, the array draws samples from a coupled energy landscape. The bits do not flip independently of one another.

A host loads a signed coupling matrix and a bias vector through a single address/data write port. It then holds `run` high. While `run` is high the array visits one bit per clock, in ascending index order. After every full sweep it presents a snapshot of all bits on `sample`, and it marks that snapshot with a one-cycle `sample_valid` strobe. Table writes are staged. A sweep already in progress keeps the table it began with.

Top module: `pbit_array`

## Requirements
- R1: After reset, `sample` is all zeros and `sample_valid` is low. All states, weights and biases are zero, and the 16-bit random register holds 0xACE1.
- R2: Address map for a write with `wr_en` high. An address a below N*N stores `wr_data` as the weight that bit a/N receives from bit a%N. Address N*N+i stores the bias of bit i. Addresses from N*N+N up to the top of the address range change nothing.
- R3: The input of bit i is its bias plus the sum, over every j other than i, of the weight i receives from j times s_j. Here s_j is +1 when bit j is 1 and -1 when bit j is 0. The weight a bit receives from itself never enters the sum.
- R4: The sum is formed without overflow and is then clamped to the range -128..127 before the decision.
- R5: The new state of the bit is 1 exactly when the clamped input is greater than r, compared as signed values. r is the low 8 bits of the random register, read as two's complement. That register is a right-shifting 16-bit Galois register: each step shifts it right by one and XORs 0xB400 into the result when the bit shifted out is 1. It steps once per bit update and holds otherwise.
- R6: While `run` is high, exactly one bit is updated per clock, in the order 0, 1, …, N-1, and the order then repeats. Each update uses the latest states of all other bits, including states changed earlier in the same sweep.
- R7: On the clock edge that updates bit N-1, `sample` loads the full state vector, with bit i of `sample` equal to bit i of the array. `sample_valid` is high for exactly the one following cycle. `sample` holds its value in every other cycle.
- R8: The weights and biases that a sweep uses are those written before the clock edge on which the sweep starts. This includes a write made on the same cycle as the last update of the previous sweep. A write made during a sweep takes effect from the next sweep.
- R9: While `run` is low, no bit changes and the random register holds. A partly finished sweep is abandoned, and the next run starts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the weight/bias table |
| wr_addr | input | 7 | Table address (see R2) |
| wr_data | input | 8 | Signed weight or bias value |
| run | input | 1 | Level; sweeps proceed while high |
| sample_valid | output | 1 | One-cycle strobe after each complete sweep |
| sample | output | 8 | Snapshot of all bit states |

## Verification
The assertions assume that `run` and the write port are driven synchronously and never carry unknown values after reset. Beyond that, they place no limit on the inputs. The stimulus writes to every address, including those past the table, with arbitrary signed data. It toggles `run` at arbitrary cycles, including mid-sweep, and it writes on the same cycle as the last update of a sweep. All inputs change shortly after a rising edge, so they are settled well before the next one.

// File: rtl/pbit_array.sv
`timescale 1ns/1ps
module pbit_array #(
  parameter int N = 8,
  parameter int WW = 8,
  parameter int RW = 16,
  parameter logic [RW-1:0] TAPS = 16'hB400,
  parameter logic [RW-1:0] SEED = 16'hACE1,
  localparam int NE = N*N + N,
  localparam int AW = $clog2(NE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic          run,
  output logic          sample_valid,
  output logic [N-1:0]  sample
);
  localparam int IW = $clog2(N);
  localparam int SW = WW + $clog2(N) + 1;
  localparam int MAXI = 2**(WW-1) - 1;
  localparam int MINI = -(2**(WW-1));

  logic signed [WW-1:0] stg [NE];
  logic signed [WW-1:0] stg_nx [NE];
  logic signed [WW-1:0] act [NE];
  logic [N-1:0]  m, m_upd;
  logic [IW-1:0] idx;
  logic [RW-1:0] lfsr;
  logic signed [SW-1:0] acc;
  logic signed [WW-1:0] isat, rnd;
  logic last, m_new;

  assign last  = (idx == IW'(N-1));
  assign rnd   = lfsr[WW-1:0];
  assign m_new = isat > rnd;

  always_comb begin
    acc = SW'(act[N*N + int'(idx)]);
    for (int j = 0; j < N; j++)
      if (j != int'(idx))
        acc = m[j] ? acc + SW'(act[int'(idx)*N + j]) : acc - SW'(act[int'(idx)*N + j]);
    if (acc > SW'(MAXI))      isat = WW'(MAXI);
    else if (acc < SW'(MINI)) isat = WW'(MINI);
    else                      isat = WW'(acc);
  end

  always_comb begin
    m_upd = m;
    m_upd[idx] = m_new;
  end

  always_comb begin
    stg_nx = stg;
    if (wr_en && int'(wr_addr) < NE) stg_nx[wr_addr] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NE; k++) begin
        stg[k] <= '0;
        act[k] <= '0;
      end
      m <= '0;
      idx <= '0;
      lfsr <= SEED;
      sample <= '0;
      sample_valid <= 1'b0;
    end else begin
      stg <= stg_nx;
      if (!run || last) act <= stg_nx;
      sample_valid <= run && last;
      if (run) begin
        m <= m_upd;
        lfsr <= {1'b0, lfsr[RW-1:1]} ^ (lfsr[0] ? TAPS : '0);
        idx <= last ? '0 : idx + 1'b1;
        if (last) sample <= m_upd;
      end else begin
        idx <= '0;
      end
    end
  end

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  a_r7_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(sample));
  a_r7_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (run && last) |=> sample_valid);
  a_r6_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> (idx == $past(idx) + 1'b1));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(lfsr) && $stable(m) && idx == '0));
  a_r5_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
endmodule

// File: tb/test_pbit_array.sv
`timescale 1ns/1ps
module test_pbit_array;
  localparam int N = 8;
  localparam int NE = N*N + N;

  logic clk = 0, rst_n = 0, wr_en = 0, run = 0;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic sample_valid;
  logic [N-1:0] sample;

  pbit_array i_pbit_array (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run(run), .sample_valid(sample_valid), .sample(sample));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  int stg [NE], act [NE];
  bit [N-1:0] mm, exp_sample;
  bit exp_valid;
  int idx;
  bit [15:0] lf;

  function automatic int clamp(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NE; k++) begin stg[k] = 0; act[k] = 0; end
    mm = '0; exp_sample = '0; exp_valid = 0; idx = 0; lf = 16'hACE1;
  endtask

  task automatic model_edge();
    bit was_last;
    int acc, r;
    was_last = (idx == N-1);
    exp_valid = 0;
    if (run) begin
      acc = act[N*N + idx];
      for (int j = 0; j < N; j++)
        if (j != idx) acc += mm[j] ? act[idx*N + j] : -act[idx*N + j];
      r = int'($signed(lf[7:0]));
      mm[idx] = (clamp(acc) > r);
      lf = {1'b0, lf[15:1]} ^ (lf[0] ? 16'hB400 : 16'h0);
      if (was_last) begin exp_sample = mm; exp_valid = 1; end
      idx = was_last ? 0 : idx + 1;
    end else idx = 0;
    if (wr_en && int'(wr_addr) < NE) stg[wr_addr] = int'($signed(wr_data));
    if (!run || was_last) for (int k = 0; k < NE; k++) act[k] = stg[k];
  endtask

  task automatic check(bit ok, string what, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act_v, exp_v);
    end
  endtask

  task automatic cycle();
    model_edge();
    @(posedge clk); #1;
    check(sample_valid == exp_valid, "R6/R7 valid", sample_valid, exp_valid);
    if (exp_valid) check(sample == exp_sample, "sample", sample, exp_sample);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 7'(a); wr_data = 8'(d);
    cycle();
    wr_en = 0;
  endtask

  task automatic sweeps(int n);
    run = 1;
    repeat (n*N) cycle();
    run = 0;
    cycle();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R1";
    check(sample == '0, "reset sample", sample, 0);
    check(sample_valid == 0, "reset valid", sample_valid, 0);

    tag = "R5";
    for (int i = 0; i < N; i++) wr(N*N + i, 127);
    sweeps(4);

    tag = "R3";
    for (int i = 0; i < N; i++) wr(N*N + i, 0);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) wr(i*N + j, (i == j) ? -128 : 9);
    sweeps(6);

    tag = "R4";
    for (int a = 0; a < NE; a++) wr(a, (a % 3 == 0) ? -128 : 127);
    sweeps(5);

    tag = "R2";
    for (int i = 0; i < 40; i++) wr(NE + ($urandom % (128 - NE)), $urandom);
    for (int i = 0; i < 10; i++) wr($urandom % NE, $urandom);
    sweeps(4);

    tag = "R8";
    run = 1;
    for (int c = 0; c < 3000; c++) begin
      wr_en = ($urandom % 3) == 0;
      wr_addr = 7'($urandom % 128);
      wr_data = 8'($urandom);
      cycle();
    end
    wr_en = 0;

    tag = "R9";
    for (int c = 0; c < 3000; c++) begin
      if ($urandom % 7 == 0) run = ~run;
      wr_en = ($urandom % 4) == 0;
      wr_addr = 7'($urandom % NE);
      wr_data = 8'($urandom);
      cycle();
    end
    wr_en = 0; run = 0;
    cycle();
    finish_up();
  end
endmodule